// File: doc/BRIEF.md
# Indirect Accelerator Descriptor Read Port

This block is a device-side register window. Through it, a configuration host reads a per-accelerator descriptor table one 32-bit word at a time. The window has three host-visible registers: an index register, an offset register and a data register. The host selects an accelerator by writing its 6-bit number into the index register. It then writes a byte offset into the offset register. That write starts a fetch of fixed, parameterised latency. The host polls the top bit of the offset register until the bit reads as one, which marks the data register as holding the requested word.

The descriptor contents are computed from the accelerator number, and a population mask parameter marks which numbers carry an accelerator at all. An unpopulated number reads as zero at every offset, so the host sees a zero header word and can skip the hole. Each populated descriptor holds the following words:
- a header word with the length and the template version;
- a 24-byte name;
- a version/type/profile word;
- two MMIO location blocks;
- a memory-size word.

A new index write or offset write cancels any fetch still in flight.

Top module: `accel_desc_port`

## Requirements
- R1: After reset the index register reads 0, the offset register reads 0 (flag clear) and the data register reads 0.
- R2: Register select `regSel` maps the registers as follows. 0 is the index, read as bits [5:0] with the upper bits 0. 1 is the offset, with the valid flag in bit 31 and the offset in bits [30:0]. 2 is the data register. 3 reads as 0 and ignores writes.
- R3: A write to the offset register with bit 31 clear starts a fetch and clears the valid flag on the same edge. Until the fetch completes, the offset register reads back the written offset with bit 31 clear.
- R4: The valid flag sets, and the data register loads, exactly FETCH_LAT clock edges after the edge that accepted the offset write.
- R5: A write to the offset register with bit 31 set is ignored. The offset, the valid flag and the data register keep their values, and no fetch starts.
- R6: A write to the index or offset register while a fetch is pending aborts that fetch. An index write on the completion edge also wins, so the valid flag stays clear. The index register holds its value unless it is written.
- R7: For a populated index, the word at offset 0x00 is 0x0058_0100: length 0x58 in [31:16], major version 1 in [15:8], minor 0 in [7:0]. For an index whose bit in POP_MASK is 0, every word reads 0.
- R8: The name occupies bytes 0x04 to 0x1B, with byte n in bits [8*(n%4)+7 : 8*(n%4)] of its word. It spells "ACC_", then the index as two decimal ASCII digits, then NUL bytes. So word 0x04 is 0x5F43_4341 and word 0x08 is {16'h0, ones digit, tens digit}.
- R9: Word 0x1C is {8'h02, 8'(index), 2'b01, 2'b10, 4'h0, 8'h10}, giving major, minor, two type fields and profile.
- R10: The MMIO words are as follows:
  - 0x20 is {16'(index+1), 13'h0, 3'd0}, giving the offset bits [31:16] and the BAR number in [2:0];
  - 0x24 is the index, as the upper offset word;
  - 0x28 is 0x0001_0000;
  - 0x30 is {16'h0400, 13'h0, 3'd2};
  - 0x34 is 0;
  - 0x38 is 0x0000_1000;
  - 0x3C is 20, the memory size as a log2 value.
  All other aligned offsets below 0x58 read 0.
- R11: An offset at or beyond 0x58, or one that is not 4-byte aligned, completes normally with valid set and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the selected register |
| regSel | input | 2 | Register select: 0 index, 1 offset, 2 data, 3 unused |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register, combinational |

## Verification
Fetch completion and fetch cancellation can fall on the same clock edge. On that edge the data register would load, and at the same time a host index write (or a fresh offset write) would cancel the fetch. The bench provokes this by writing the index exactly FETCH_LAT-1 cycles after an offset write, so that the index write lands on the completion edge. It judges the outcome by requiring the valid flag to stay clear. Checks on an abort one cycle into a fetch and on an offset rewrite mid-fetch complete the picture, and the rewritten offset must complete with its own data, FETCH_LAT edges after the second write.

// File: rtl/desc_port_pkg.sv
package desc_port_pkg;

  localparam int IDX_W   = 6;
  localparam int DATA_W  = 32;
  localparam int OFF_W   = 31;
  localparam logic [OFF_W-1:0] DESC_LEN = 31'h58;

  localparam logic [1:0] SEL_INDEX  = 2'd0;
  localparam logic [1:0] SEL_OFFSET = 2'd1;
  localparam logic [1:0] SEL_DATA   = 2'd2;

  typedef struct packed {
    logic loadData;   // fetch completes: capture word, set flag
    logic clearValid; // new fetch or abort: drop flag
  } strobe_t;

  function automatic logic [DATA_W-1:0] nameWord(input logic [IDX_W-1:0] idx,
                                                 input logic [2:0] slot);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = 8'h30 + (8'(idx) / 8'd10);
    ones = 8'h30 + (8'(idx) % 8'd10);
    case (slot)
      3'd0:    nameWord = 32'h5F43_4341;
      3'd1:    nameWord = {16'h0000, ones, tens};
      default: nameWord = '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] descWord(input logic [IDX_W-1:0] idx,
                                                 input logic [4:0] wordNum);
    logic [DATA_W-1:0] w;
    w = '0;
    case (wordNum)
      5'd0:  w = 32'h0058_0100;
      5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6:
             w = nameWord(idx, 3'(wordNum - 5'd1));
      5'd7:  w = {8'h02, 8'(idx), 2'b01, 2'b10, 4'h0, 8'h10};
      5'd8:  w = {16'(idx) + 16'd1, 13'h0, 3'd0};
      5'd9:  w = {26'h0, idx};
      5'd10: w = 32'h0001_0000;
      5'd12: w = {16'h0400, 13'h0, 3'd2};
      5'd13: w = 32'h0;
      5'd14: w = 32'h0000_1000;
      5'd15: w = 32'd20;
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/desc_store.sv
module desc_store
  import desc_port_pkg::*;
#(
  parameter logic [63:0] POP_MASK = 64'hFFFF_0000_FFFF_FFDB
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  byteOff,
  output logic [DATA_W-1:0] word
);

  localparam int N_IDX = 1 << IDX_W;

  logic [N_IDX-1:0] populated;
  logic             inRange;

  genvar g;
  generate
    for (g = 0; g < N_IDX; g++) begin : g_pop
      assign populated[g] = POP_MASK[g];
    end
  endgenerate

  assign inRange = (byteOff < DESC_LEN) && (byteOff[1:0] == 2'b00);

  always_comb begin
    if (populated[idx] && inRange) word = descWord(idx, byteOff[6:2]);
    else                           word = '0;
  end

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import desc_port_pkg::*;
#(
  parameter int FETCH_LAT = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    offWr,
  input  logic    idxWr,
  output strobe_t strb
);

  localparam int CNT_W = $clog2(FETCH_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FETCH_LAT - 1);

  logic             pending;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strb.clearValid = offWr || idxWr;
    strb.loadData   = pending && (cnt == '0) && !offWr && !idxWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (offWr) begin
      pending <= 1'b1;
      cnt     <= CNT_LOAD;
    end else if (idxWr) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (strb.loadData) begin
      pending <= 1'b0;
    end else if (pending) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/window_dp.sv
module window_dp
  import desc_port_pkg::*;
#(
  parameter logic [63:0] POP_MASK = 64'hFFFF_0000_FFFF_FFDB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              offWr,
  input  logic              idxWr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [1:0]        regSel,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] regRdData,
  output logic              validQ,
  output logic [OFF_W-1:0]  offsetQ,
  output logic [IDX_W-1:0]  indexQ
);

  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] storeWord;

  desc_store #(.POP_MASK(POP_MASK)) u_store (
    .idx    (indexQ),
    .byteOff(offsetQ),
    .word   (storeWord)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ  <= '0;
      offsetQ <= '0;
      dataQ   <= '0;
      validQ  <= 1'b0;
    end else begin
      if (idxWr) indexQ <= regWrData[IDX_W-1:0];
      if (offWr) offsetQ <= regWrData[OFF_W-1:0];
      if (strb.clearValid)     validQ <= 1'b0;
      else if (strb.loadData)  validQ <= 1'b1;
      if (strb.loadData) dataQ <= storeWord;
    end
  end

  always_comb begin
    case (regSel)
      SEL_INDEX:  regRdData = {{(DATA_W-IDX_W){1'b0}}, indexQ};
      SEL_OFFSET: regRdData = {validQ, offsetQ};
      SEL_DATA:   regRdData = dataQ;
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/accel_desc_port.sv
module accel_desc_port
  import desc_port_pkg::*;
#(
  parameter int          FETCH_LAT = 4,
  parameter logic [63:0] POP_MASK  = 64'hFFFF_0000_FFFF_FFDB
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData
);

  strobe_t          strb;
  logic             offWr;
  logic             idxWr;
  logic             validQ;
  logic [OFF_W-1:0] offsetQ;
  logic [IDX_W-1:0] indexQ;

  assign offWr = regWrEn && (regSel == SEL_OFFSET) && !regWrData[31];
  assign idxWr = regWrEn && (regSel == SEL_INDEX);

  fetch_ctrl #(.FETCH_LAT(FETCH_LAT)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .offWr(offWr),
    .idxWr(idxWr),
    .strb (strb)
  );

  window_dp #(.POP_MASK(POP_MASK)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .offWr    (offWr),
    .idxWr    (idxWr),
    .regWrData(regWrData),
    .regSel   (regSel),
    .strb     (strb),
    .regRdData(regRdData),
    .validQ   (validQ),
    .offsetQ  (offsetQ),
    .indexQ   (indexQ)
  );

endmodule

// File: rtl/desc_port_checker.sv
module desc_port_checker
  import desc_port_pkg::*;
#(
  parameter int FETCH_LAT = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [1:0]       regSel,
  input logic [31:0]      regWrData,
  input strobe_t          strb,
  input logic             validQ,
  input logic [OFF_W-1:0] offsetQ,
  input logic [IDX_W-1:0] indexQ
);

  localparam int SW = $clog2(FETCH_LAT + 2) + 1;
  localparam logic [SW-1:0] SMAX = {SW{1'b1}};

  logic hostStart, hostIdx, hostBadOff;
  logic [SW-1:0] since;

  assign hostStart  = regWrEn && regSel == SEL_OFFSET && !regWrData[31];
  assign hostIdx    = regWrEn && regSel == SEL_INDEX;
  assign hostBadOff = regWrEn && regSel == SEL_OFFSET && regWrData[31];

  always_ff @(posedge clk) begin
    if (!rstN)              since <= '0;
    else if (hostStart)     since <= SW'(1);
    else if (since != '0 && since != SMAX) since <= since + 1'b1;
  end

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    hostStart |=> !validQ);

  assert_load_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData |-> since == SW'(FETCH_LAT));

  assert_load_sets_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData |=> validQ);

  assert_bad_offset_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostBadOff |=> $stable(offsetQ) && $stable(validQ));

  assert_index_abort_R6: assert property (@(posedge clk) disable iff (!rstN)
    hostIdx |=> !validQ);

  assert_index_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !hostIdx |=> $stable(indexQ));

endmodule

bind accel_desc_port desc_port_checker #(.FETCH_LAT(FETCH_LAT)) u_chk (.*);

// File: tb/test_accel_desc_port.sv
module test_accel_desc_port;

  localparam int          LAT  = 4;
  localparam logic [63:0] MASK = 64'hFFFF_0000_FFFF_FFDB;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  accel_desc_port #(.FETCH_LAT(LAT), .POP_MASK(MASK)) i_accel_desc_port (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData));

  // Expected descriptor word from the requirement text (R7-R11)
  function automatic logic [31:0] expWord(input int idx, input int off);
    int t, o;
    if (!MASK[idx]) return 32'h0;
    if (off >= 'h58 || (off % 4) != 0) return 32'h0;
    t = idx / 10;
    o = idx % 10;
    case (off)
      'h00: return 32'h0058_0100;
      'h04: return {8'h5F, 8'h43, 8'h43, 8'h41};
      'h08: return {16'h0, 8'(8'h30 + o), 8'(8'h30 + t)};
      'h1C: return {8'h02, 8'(idx), 4'b0110, 4'h0, 8'h10};
      'h20: return {16'(idx + 1), 16'h0000};
      'h24: return 32'(idx);
      'h28: return 32'h0001_0000;
      'h30: return 32'h0400_0002;
      'h38: return 32'h0000_1000;
      'h3C: return 32'd20;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    regSel = sel;
    #1;
    d = regRdData;
  endtask

  // Full fetch with latency checks (R3, R4)
  task automatic fetch(input int idx, input int off);
    logic [31:0] v;
    wr(2'd0, 32'(idx));
    wr(2'd1, 32'(off));
    for (int k = 0; k < LAT; k++) begin
      rd(2'd1, v);
      check("R3 pending offset readback", v, {1'b0, 31'(off)});
      @(negedge clk);
    end
    rd(2'd1, v);
    check("R4 valid after latency", v, {1'b1, 31'(off)});
    rd(2'd2, v);
    check("R7-R11 data word", v, expWord(idx, off));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 index reset", v, 32'h0);
    rd(2'd1, v); check("R1 offset reset", v, 32'h0);
    rd(2'd2, v); check("R1 data reset", v, 32'h0);

    // R2 register map, unused slot
    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, v); check("R2 unused select", v, 32'h0);
    wr(2'd0, 32'hFFFF_FFC5);
    rd(2'd0, v); check("R2 index width", v, 32'h05);

    // Directed descriptor words: R7 R8 R9 R10
    fetch(12, 'h00);
    fetch(12, 'h04);
    fetch(37, 'h08);
    fetch(63, 'h1C);
    fetch(9, 'h20);
    fetch(9, 'h24);
    fetch(9, 'h28);
    fetch(1, 'h30);
    fetch(1, 'h38);
    fetch(1, 'h3C);
    // R7 holes
    fetch(2, 'h00);
    fetch(40, 'h1C);
    // R11 out of range and unaligned
    fetch(3, 'h58);
    fetch(3, 'h1E);

    // R5 ignored offset write with bit 31 set
    rd(2'd2, v);
    begin
      logic [31:0] oldData;
      oldData = v;
      wr(2'd1, 32'h8000_0010);
      repeat (LAT + 1) @(negedge clk);
      rd(2'd1, v); check("R5 offset unchanged", v, {1'b1, 31'h1E});
      rd(2'd2, v); check("R5 data unchanged", v, oldData);
    end

    // R6 abort by index write one cycle into fetch
    wr(2'd0, 32'd4);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'd6);
    repeat (LAT + 2) @(negedge clk);
    rd(2'd1, v); check("R6 abort by index", v, 32'h0);

    // R6 index write on the completion edge wins
    wr(2'd1, 32'h1C);
    repeat (LAT - 1) @(negedge clk);
    wr(2'd0, 32'd7);
    rd(2'd1, v); check("R6 collision valid clear", v, 32'h1C);
    repeat (LAT + 2) @(negedge clk);
    rd(2'd1, v); check("R6 collision stays clear", v, 32'h1C);
    rd(2'd0, v); check("R6 index updated", v, 32'd7);

    // R6 offset rewrite mid-fetch restarts with new offset
    wr(2'd1, 32'h00);
    @(negedge clk);
    wr(2'd1, 32'h24);
    for (int k = 0; k < LAT; k++) begin
      rd(2'd1, v); check("R6 restart pending", v, 32'h24);
      @(negedge clk);
    end
    rd(2'd1, v); check("R6 restart valid", v, {1'b1, 31'h24});
    rd(2'd2, v); check("R6 restart data", v, expWord(7, 'h24));

    // Random mix: R4 R7 R8 R9 R10 R11
    for (int n = 0; n < 120; n++) begin
      int idx, off;
      idx = int'($urandom_range(0, 63));
      if ($urandom_range(0, 7) == 0) off = int'($urandom_range(0, 127));
      else off = 4 * int'($urandom_range(0, 21));
      fetch(idx, off);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule